// File: doc/BRIEF.md
# Partial Pre-SET Write Scheduler

This block sits in front of a phase-change main memory and shortens writebacks without wearing out cells that will never change. A SET pulse on this kind of memory takes about eight times as long as a RESET pulse. When the cache reports that a single word of a line has just become dirty, the scheduler sends a SET to that one memory word straight away, long before the writeback arrives. The other words of the line get no early SET, so the wear of a whole-line early SET is avoided.

A small table records which words of each tracked line have already been SET early. When the writeback comes, those words need only the short RESET pulse. Any dirty word without an early SET takes the full path: a SET, then a RESET. Writebacks take the command port ahead of queued early SETs, and early SETs go out in the order their notifications arrived. A running count of SET word operations lets a testbench compare wear against a policy that SETs the whole line.

On the command port, a SET is held for 8 cycles and a RESET for 1 cycle. The memory model, the cache tags and wear levelling are outside this block.

Top module: `pset_sched`

## Requirements
- R1: `cmd_op` is encoded 0 = idle, 1 = SET, 2 = RESET. A SET command stays on the port for exactly 8 consecutive cycles and a RESET for exactly 1. Every command is followed by at least one idle cycle, and `cmd_mask` is non-zero whenever `cmd_op` is not idle.
- R2: A dirty notification for word `w` of line `L` produces one SET command with `cmd_line` = L and `cmd_mask` = 1 << w. Words of `L` that were not notified receive no SET.
- R3: A notification for a word that already has an early SET queued, running or completed is ignored: no second SET is issued and `set_count` does not change.
- R4: Early SETs are issued in the order their notifications were accepted.
- R5: At writeback, if every dirty word (bit set in `wb_mask`) has already been SET early, the only command is one RESET. It carries `cmd_mask` = `wb_mask`, `cmd_line` = `wb_line` and `cmd_data` = `wb_data`.
- R6: Dirty words without a completed early SET are written in full. This is one SET whose mask holds exactly those words, then one RESET whose mask is the whole `wb_mask`.
- R7: A writeback accepted while an early SET for its line is running waits until that SET ends, and counts the word as done. A queued early SET for that line that has not yet started is cancelled, and its word takes the full path instead.
- R8: When `wb_valid` is high in a cycle where the scheduler has no writeback in progress, the writeback is accepted and its commands are issued before any queued early SET.
- R9: A writeback is accepted when `wb_valid` is high and `wb_busy` is low. `wb_busy` stays high until the writeback finishes, and `wb_done` then pulses for one cycle. Completion clears the line's early-SET record and frees its table entry, so a later notification for the same word issues a new SET.
- R10: The table tracks at most 4 lines, and the early-SET queue holds 8 requests. A notification for an untracked line while all 4 entries are in use, or any notification while the queue is full, is ignored. That line's dirty words are later written in full.
- R11: `set_count` increases by the number of set bits in `cmd_mask` in the first cycle of each SET command, and it changes at no other time.
- R12: A writeback with `wb_mask` = 0 issues no command and still produces a `wb_done` pulse.
- R13: After reset, `cmd_op` is idle, `cmd_mask` is 0, `wb_busy` and `wb_done` are low, and `set_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dn_valid | input | 1 | Dirty-word notification strobe |
| dn_line | input | 8 | Line address of the notified word |
| dn_word | input | 3 | Index of the notified word within the line |
| wb_valid | input | 1 | Writeback request |
| wb_line | input | 8 | Writeback line address |
| wb_mask | input | 8 | Dirty words of the writeback, one bit per word |
| wb_data | input | 64 | Writeback data, word i in bits 8i+7..8i |
| wb_busy | output | 1 | A writeback is being processed |
| wb_done | output | 1 | One-cycle pulse when a writeback finishes |
| cmd_op | output | 2 | Memory command: 0 idle, 1 SET, 2 RESET |
| cmd_line | output | 8 | Line address of the current command |
| cmd_mask | output | 8 | Words touched by the current command |
| cmd_data | output | 64 | Data carried with a writeback command |
| set_count | output | 16 | Running total of SET word operations |

## Verification
A stale or missing early-SET record appears at the port on the very next writeback to that line. A word that should have gone RESET-only comes out with an extra 8-cycle SET, or a word that needed a full write is sent only a RESET. In both cases the mismatch is visible in the command sequence within about ten cycles of the writeback being accepted. A wrong queue order or a lost cancellation shows up as a SET command on the wrong line or word, or as a SET issued after its line was written back. The running SET count differs from the arithmetic popcount total as soon as the first such command starts.

// File: rtl/pset_pkg.sv
// Shared types for the partial pre-SET scheduler.
// Assumes: a two-bit command code is enough for idle, SET and RESET.
package pset_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SET   = 2'd1,
        OP_RESET = 2'd2
    } cmd_op_e;

    typedef enum logic [1:0] {
        WB_IDLE = 2'd0,
        WB_WAIT = 2'd1,
        WB_SETP = 2'd2,
        WB_RSTP = 2'd3
    } wb_state_e;

endpackage

// File: rtl/pset_fifo.sv
// Request queue for early SET requests, served oldest first.
// Assumes: the writer never pushes while full and the reader never pops
// while empty (both are also guarded here).
module pset_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == DEPTH_C);
    assign rdata   = mem_q[rp_q];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wp_q] <= wdata;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/pset_table.sv
// Line table: for each tracked line, the words with an early SET queued or
// running (pend) and the words whose early SET has finished (done).
// Assumes: free_en has priority over an allocation to the same entry in the
// same cycle; at most one notification per cycle.
module pset_table #(
    parameter int LA_W  = 8,
    parameter int WORDS = 8,
    parameter int LINES = 4,
    localparam int WI_W = $clog2(WORDS),
    localparam int LI_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dn_valid,
    input  logic [LA_W-1:0]  dn_line,
    input  logic [WI_W-1:0]  dn_word,
    input  logic             q_full,
    output logic             enq,
    output logic [LI_W-1:0]  enq_idx,
    input  logic [LA_W-1:0]  lk_line,
    output logic             lk_hit,
    output logic [LI_W-1:0]  lk_idx,
    output logic [WORDS-1:0] lk_done,
    input  logic [LI_W-1:0]  chk_idx,
    input  logic [WI_W-1:0]  chk_word,
    output logic             chk_live,
    output logic [LA_W-1:0]  chk_tag,
    input  logic             done_en,
    input  logic [LI_W-1:0]  done_idx,
    input  logic [WI_W-1:0]  done_word,
    input  logic             free_en,
    input  logic [LI_W-1:0]  free_idx
);
    logic             vld_q  [LINES];
    logic [LA_W-1:0]  tag_q  [LINES];
    logic [WORDS-1:0] done_q [LINES];
    logic [WORDS-1:0] pend_q [LINES];

    logic            m_hit, f_ok, known;
    logic [LI_W-1:0] m_idx, f_idx;

    // Match the notified line, find the first free entry, decide acceptance.
    always_comb begin
        m_hit = 1'b0;
        m_idx = '0;
        f_ok  = 1'b0;
        f_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (vld_q[i] && tag_q[i] == dn_line && !m_hit) begin
                m_hit = 1'b1;
                m_idx = LI_W'(i);
            end
            if (!vld_q[i] && !f_ok) begin
                f_ok  = 1'b1;
                f_idx = LI_W'(i);
            end
        end
        known   = m_hit && (done_q[m_idx][dn_word] || pend_q[m_idx][dn_word]);
        enq     = dn_valid && !q_full && !known && (m_hit || f_ok);
        enq_idx = m_hit ? m_idx : f_idx;
    end

    // Look up the line of the writeback in progress.
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (vld_q[i] && tag_q[i] == lk_line && !lk_hit) begin
                lk_hit = 1'b1;
                lk_idx = LI_W'(i);
            end
        end
        lk_done = done_q[lk_idx];
    end

    // Is the queue head still wanted, and which line does it target.
    assign chk_live = vld_q[chk_idx] && pend_q[chk_idx][chk_word];
    assign chk_tag  = tag_q[chk_idx];

    // Entry state update: completion, allocation, then release (release wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                vld_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                done_q[i] <= '0;
                pend_q[i] <= '0;
            end
        end else begin
            if (done_en) begin
                done_q[done_idx][done_word] <= 1'b1;
                pend_q[done_idx][done_word] <= 1'b0;
            end
            if (enq) begin
                vld_q[enq_idx]           <= 1'b1;
                tag_q[enq_idx]           <= dn_line;
                pend_q[enq_idx][dn_word] <= 1'b1;
            end
            if (free_en) begin
                vld_q[free_idx]  <= 1'b0;
                done_q[free_idx] <= '0;
                pend_q[free_idx] <= '0;
            end
        end
    end

endmodule

// File: rtl/pset_port.sv
// Command port timer: holds each command for its pulse length, then leaves
// one idle cycle, and counts SET word operations.
// Assumes: start is raised only while idle is high.
module pset_port
    import pset_pkg::*;
#(
    parameter int LA_W      = 8,
    parameter int WORDS     = 8,
    parameter int DATA_W    = 64,
    parameter int SET_CYC   = 8,
    parameter int RESET_CYC = 1,
    parameter int CNT_W     = 16,
    localparam int TW       = $clog2(SET_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_op_e           s_op,
    input  logic [LA_W-1:0]   s_line,
    input  logic [WORDS-1:0]  s_mask,
    input  logic [DATA_W-1:0] s_data,
    output logic              idle,
    output logic              fin,
    output cmd_op_e           op_q,
    output logic [LA_W-1:0]   line_q,
    output logic [WORDS-1:0]  mask_q,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  set_count
);
    localparam logic [TW-1:0] SET_LAST = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] RST_LAST = TW'(RESET_CYC - 1);

    logic [TW-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] ones(input logic [WORDS-1:0] v);
        ones = '0;
        for (int k = 0; k < WORDS; k++) begin
            ones = ones + CNT_W'(v[k]);
        end
    endfunction

    assign idle = (op_q == OP_IDLE);
    assign fin  = !idle && (cnt_q == '0);

    // Load a command, count down its pulse, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_IDLE;
            cnt_q     <= '0;
            line_q    <= '0;
            mask_q    <= '0;
            data_q    <= '0;
            set_count <= '0;
        end else if (start) begin
            op_q   <= s_op;
            cnt_q  <= (s_op == OP_SET) ? SET_LAST : RST_LAST;
            line_q <= s_line;
            mask_q <= s_mask;
            data_q <= s_data;
            if (s_op == OP_SET) begin
                set_count <= set_count + ones(s_mask);
            end
        end else if (!idle) begin
            if (cnt_q == '0) begin
                op_q   <= OP_IDLE;
                mask_q <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pset_sched.sv
// Partial pre-SET write scheduler (top). Queues a one-word early SET per
// dirty notification, and sequences each writeback as RESET-only for words
// already SET early, or SET then RESET for the rest.
// Assumes: writeback data stays valid only while wb_valid is high (it is
// latched on acceptance); the memory accepts every command immediately.
module pset_sched
    import pset_pkg::*;
#(
    parameter int LA_W      = 8,
    parameter int WORDS     = 8,
    parameter int WORD_W    = 8,
    parameter int LINES     = 4,
    parameter int QDEPTH    = 8,
    parameter int SET_CYC   = 8,
    parameter int RESET_CYC = 1,
    parameter int CNT_W     = 16,
    localparam int WI_W     = $clog2(WORDS),
    localparam int LI_W     = $clog2(LINES),
    localparam int DATA_W   = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dn_valid,
    input  logic [LA_W-1:0]   dn_line,
    input  logic [WI_W-1:0]   dn_word,
    input  logic              wb_valid,
    input  logic [LA_W-1:0]   wb_line,
    input  logic [WORDS-1:0]  wb_mask,
    input  logic [DATA_W-1:0] wb_data,
    output logic              wb_busy,
    output logic              wb_done,
    output logic [1:0]        cmd_op,
    output logic [LA_W-1:0]   cmd_line,
    output logic [WORDS-1:0]  cmd_mask,
    output logic [DATA_W-1:0] cmd_data,
    output logic [CNT_W-1:0]  set_count
);
    localparam int QW = LI_W + WI_W;

    wb_state_e         st_q, st_d;
    logic [LA_W-1:0]   wl_q;
    logic [WORDS-1:0]  wm_q;
    logic [DATA_W-1:0] wd_q;
    logic              pre_act_q;
    logic [LI_W-1:0]   pre_idx_q;
    logic [WI_W-1:0]   pre_word_q;

    logic              enq, q_empty, q_full, pop;
    logic [LI_W-1:0]   enq_idx, lk_idx, chk_idx;
    logic [WI_W-1:0]   chk_word;
    logic [QW-1:0]     q_rdata;
    logic              lk_hit, chk_live;
    logic [WORDS-1:0]  lk_done, full_m;
    logic [LA_W-1:0]   chk_tag;

    logic              start, pre_start, wb_fin, port_idle, port_fin;
    cmd_op_e           s_op, op_w;
    logic [LA_W-1:0]   s_line;
    logic [WORDS-1:0]  s_mask;
    logic [DATA_W-1:0] s_data;

    assign chk_idx  = q_rdata[QW-1:WI_W];
    assign chk_word = q_rdata[WI_W-1:0];

    pset_table #(.LA_W(LA_W), .WORDS(WORDS), .LINES(LINES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .dn_valid(dn_valid), .dn_line(dn_line), .dn_word(dn_word),
        .q_full(q_full), .enq(enq), .enq_idx(enq_idx),
        .lk_line(wl_q), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_done(lk_done),
        .chk_idx(chk_idx), .chk_word(chk_word), .chk_live(chk_live),
        .chk_tag(chk_tag),
        .done_en(port_fin && pre_act_q), .done_idx(pre_idx_q),
        .done_word(pre_word_q),
        .free_en(wb_fin && lk_hit), .free_idx(lk_idx)
    );

    pset_fifo #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(enq), .wdata({enq_idx, dn_word}),
        .pop(pop), .rdata(q_rdata),
        .empty(q_empty), .full(q_full)
    );

    pset_port #(
        .LA_W(LA_W), .WORDS(WORDS), .DATA_W(DATA_W),
        .SET_CYC(SET_CYC), .RESET_CYC(RESET_CYC), .CNT_W(CNT_W)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .start(start), .s_op(s_op), .s_line(s_line), .s_mask(s_mask),
        .s_data(s_data),
        .idle(port_idle), .fin(port_fin),
        .op_q(op_w), .line_q(cmd_line), .mask_q(cmd_mask), .data_q(cmd_data),
        .set_count(set_count)
    );

    assign cmd_op  = op_w;
    assign wb_busy = (st_q != WB_IDLE);
    assign full_m  = wm_q & ~(lk_hit ? lk_done : '0);

    // Arbitrate the port: writeback sequence first, else the queue head.
    always_comb begin
        st_d      = st_q;
        start     = 1'b0;
        pre_start = 1'b0;
        pop       = 1'b0;
        wb_fin    = 1'b0;
        s_op      = OP_IDLE;
        s_line    = wl_q;
        s_mask    = '0;
        s_data    = wd_q;
        case (st_q)
            WB_IDLE: begin
                if (wb_valid) begin
                    st_d = WB_WAIT;
                end else if (port_idle && !q_empty) begin
                    pop = 1'b1;
                    if (chk_live) begin
                        pre_start = 1'b1;
                        start     = 1'b1;
                        s_op      = OP_SET;
                        s_line    = chk_tag;
                        s_mask    = WORDS'(1) << chk_word;
                        s_data    = '0;
                    end
                end
            end
            WB_WAIT: begin
                if (port_idle) begin
                    if (wm_q == '0) begin
                        wb_fin = 1'b1;
                        st_d   = WB_IDLE;
                    end else if (full_m != '0) begin
                        start  = 1'b1;
                        s_op   = OP_SET;
                        s_mask = full_m;
                        st_d   = WB_SETP;
                    end else begin
                        start  = 1'b1;
                        s_op   = OP_RESET;
                        s_mask = wm_q;
                        st_d   = WB_RSTP;
                    end
                end
            end
            WB_SETP: begin
                if (port_idle) begin
                    start  = 1'b1;
                    s_op   = OP_RESET;
                    s_mask = wm_q;
                    st_d   = WB_RSTP;
                end
            end
            default: begin
                if (port_idle) begin
                    wb_fin = 1'b1;
                    st_d   = WB_IDLE;
                end
            end
        endcase
    end

    // Writeback state, request latch, done pulse and in-flight early SET.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WB_IDLE;
            wl_q       <= '0;
            wm_q       <= '0;
            wd_q       <= '0;
            wb_done    <= 1'b0;
            pre_act_q  <= 1'b0;
            pre_idx_q  <= '0;
            pre_word_q <= '0;
        end else begin
            st_q    <= st_d;
            wb_done <= wb_fin;
            if (st_q == WB_IDLE && wb_valid) begin
                wl_q <= wb_line;
                wm_q <= wb_mask;
                wd_q <= wb_data;
            end
            if (pre_start) begin
                pre_act_q  <= 1'b1;
                pre_idx_q  <= chk_idx;
                pre_word_q <= chk_word;
            end else if (port_fin) begin
                pre_act_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pset_sched_chk.sv
// Port-level checker for pset_sched, attached by bind below.
// Assumes: RESET_CYC does not exceed SET_CYC.
module pset_sched_chk
    import pset_pkg::*;
#(
    parameter int WORDS     = 8,
    parameter int SET_CYC   = 8,
    parameter int RESET_CYC = 1,
    parameter int CNT_W     = 16,
    localparam int RW       = $clog2(SET_CYC + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_op,
    input logic [WORDS-1:0] cmd_mask,
    input logic [CNT_W-1:0] set_count,
    input logic             wb_busy,
    input logic             wb_done
);
    logic [RW-1:0] set_run, rst_run;

    // Length of the current run of SET and RESET cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_run <= '0;
            rst_run <= '0;
        end else begin
            set_run <= (cmd_op == OP_SET)   ? set_run + 1'b1 : '0;
            rst_run <= (cmd_op == OP_RESET) ? rst_run + 1'b1 : '0;
        end
    end

    assert_set_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != OP_SET && $past(cmd_op) == OP_SET) |-> set_run == RW'(SET_CYC));

    assert_reset_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != OP_RESET && $past(cmd_op) == OP_RESET) |-> rst_run == RW'(RESET_CYC));

    assert_idle_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_op) != OP_IDLE && cmd_op != $past(cmd_op)) |-> cmd_op == OP_IDLE);

    assert_mask_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != OP_IDLE) |-> cmd_mask != '0);

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_SET && $past(cmd_op) != OP_SET)
            |-> set_count == $past(set_count) + CNT_W'($countones(cmd_mask)));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_op == OP_SET && $past(cmd_op) != OP_SET) |-> $stable(set_count));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> !wb_done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |-> (!wb_busy && cmd_op == OP_IDLE));

endmodule

bind pset_sched pset_sched_chk #(
    .WORDS(WORDS), .SET_CYC(SET_CYC), .RESET_CYC(RESET_CYC), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_mask(cmd_mask),
    .set_count(set_count), .wb_busy(wb_busy), .wb_done(wb_done)
);

// File: tb/pset_sched_bench.sv
`timescale 1ns/1ps
module pset_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dn_valid = 1'b0;
    logic [7:0]  dn_line = '0;
    logic [2:0]  dn_word = '0;
    logic        wb_valid = 1'b0;
    logic [7:0]  wb_line = '0;
    logic [7:0]  wb_mask = '0;
    logic [63:0] wb_data = '0;
    logic        wb_busy, wb_done;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_line, cmd_mask;
    logic [63:0] cmd_data;
    logic [15:0] set_count;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pset_sched u_pset_sched (
        .clk(clk), .rst_n(rst_n),
        .dn_valid(dn_valid), .dn_line(dn_line), .dn_word(dn_word),
        .wb_valid(wb_valid), .wb_line(wb_line), .wb_mask(wb_mask),
        .wb_data(wb_data), .wb_busy(wb_busy), .wb_done(wb_done),
        .cmd_op(cmd_op), .cmd_line(cmd_line), .cmd_mask(cmd_mask),
        .cmd_data(cmd_data), .set_count(set_count)
    );

    // Command log, sampled at the falling edge.
    int          lg_op   [64];
    int          lg_len  [64];
    logic [7:0]  lg_line [64];
    logic [7:0]  lg_mask [64];
    logic [63:0] lg_data [64];
    int nlog = 0;
    int prev_op = 0;
    int done_cnt = 0;

    always @(negedge clk) begin
        if (cmd_op != 2'd0) begin
            if (prev_op == 0) begin
                if (nlog < 64) begin
                    lg_op[nlog]   = int'(cmd_op);
                    lg_len[nlog]  = 1;
                    lg_line[nlog] = cmd_line;
                    lg_mask[nlog] = cmd_mask;
                    lg_data[nlog] = cmd_data;
                end
                nlog++;
            end else if (nlog > 0 && nlog <= 64) begin
                lg_len[nlog-1]++;
            end
        end
        prev_op = int'(cmd_op);
        if (wb_done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic notify(input logic [7:0] line, input int w);
        @(negedge clk);
        dn_valid = 1'b1;
        dn_line  = line;
        dn_word  = 3'(w);
        @(negedge clk);
        dn_valid = 1'b0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            if (cmd_op == 2'd0 && !wb_busy) q++;
            else q = 0;
        end
    endtask

    task automatic writeback(input logic [7:0] line, input logic [7:0] m, input logic [63:0] d);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_line  = line;
        wb_mask  = m;
        wb_data  = d;
        do @(negedge clk); while (!wb_busy);
        wb_valid = 1'b0;
        while (wb_busy) @(negedge clk);
        quiet();
    endtask

    function automatic bit is_set(int k, logic [7:0] line, logic [7:0] m);
        return lg_op[k] == 1 && lg_len[k] == 8 && lg_line[k] == line && lg_mask[k] == m;
    endfunction

    function automatic bit is_rst(int k, logic [7:0] line, logic [7:0] m, logic [63:0] d);
        return lg_op[k] == 2 && lg_len[k] == 1 && lg_line[k] == line &&
               lg_mask[k] == m && lg_data[k] == d;
    endfunction

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int c0;
        int partial_sets = 0;
        int whole_sets = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(cmd_op == 0 && cmd_mask == 0, "R13 command idle", cmd_op, 0);
        chk(!wb_busy && !wb_done, "R13 handshake low", wb_busy, 0);
        chk(set_count == 0, "R13 set_count", set_count, 0);

        // R1 R2 R4 R5 R9 R11 R12: every dirty pattern, all words pre-SET
        for (int m = 0; m < 256; m++) begin
            logic [7:0]  mm;
            logic [7:0]  ln;
            logic [63:0] d;
            bit ok;
            int k;
            mm = 8'(m);
            ln = 8'(m);
            d  = {8{mm ^ 8'hA5}} ^ 64'(m * 977);
            c0 = int'(set_count);
            nlog = 0;
            for (int w = 0; w < 8; w++) if (mm[w]) notify(ln, w);
            quiet();
            ok = (nlog == $countones(mm));
            k = 0;
            for (int w = 0; w < 8; w++) begin
                if (mm[w]) begin
                    if (k < nlog && !is_set(k, ln, 8'(1 << w))) ok = 0;
                    k++;
                end
            end
            chk(ok, "R1 R2 R4 pre-SET per word", nlog, $countones(mm));
            nlog = 0;
            done_cnt = 0;
            writeback(ln, mm, d);
            if (mm == 0) chk(nlog == 0, "R12 empty writeback", nlog, 0);
            else chk(nlog == 1 && is_rst(0, ln, mm, d), "R5 RESET only", nlog, 1);
            chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
            chk(int'(set_count) - c0 == $countones(mm), "R11 count", int'(set_count) - c0, $countones(mm));
            partial_sets += $countones(mm);
            if (mm != 0) whole_sets += 8;
        end
        $display("[TB] SET words: partial %0d, whole-line %0d", partial_sets, whole_sets);

        // R6: no notifications, every writeback is a full write
        for (int m = 1; m < 256; m++) begin
            logic [7:0]  mm;
            logic [63:0] d;
            mm = 8'(m);
            d  = {8{~mm}};
            c0 = int'(set_count);
            nlog = 0;
            writeback(mm, mm, d);
            chk(nlog == 2 && is_set(0, mm, mm) && is_rst(1, mm, mm, d), "R6 full write", nlog, 2);
            chk(int'(set_count) - c0 == $countones(mm), "R6 R11 count", int'(set_count) - c0, $countones(mm));
        end

        // R5 R6: partial pre-SET then a writeback of a superset
        for (int m = 0; m < 256; m += 3) begin
            logic [7:0]  mm, p, rest;
            logic [63:0] d;
            int en;
            mm = 8'(m);
            p  = mm & 8'h5A;
            rest = mm & ~p;
            d  = {8{mm}} + 64'(m);
            for (int w = 0; w < 8; w++) if (p[w]) notify(8'(m + 1), w);
            quiet();
            nlog = 0;
            writeback(8'(m + 1), mm, d);
            en = (rest != 0) ? 2 : ((mm != 0) ? 1 : 0);
            if (en == 2) chk(nlog == 2 && is_set(0, 8'(m + 1), rest) && is_rst(1, 8'(m + 1), mm, d), "R6 mixed", nlog, 2);
            else if (en == 1) chk(nlog == 1 && is_rst(0, 8'(m + 1), mm, d), "R5 mixed", nlog, 1);
            else chk(nlog == 0, "R12 mixed", nlog, 0);
        end

        // R3: duplicate notifications
        nlog = 0;
        c0 = int'(set_count);
        notify(8'd9, 2);
        notify(8'd9, 2);
        quiet();
        notify(8'd9, 2);
        quiet();
        chk(nlog == 1 && int'(set_count) - c0 == 1, "R3 duplicate ignored", nlog, 1);
        nlog = 0;
        writeback(8'd9, 8'h04, 64'h1234);
        chk(nlog == 1 && is_rst(0, 8'd9, 8'h04, 64'h1234), "R3 R5 writeback", nlog, 1);

        // R10: table capacity
        nlog = 0;
        for (int i = 0; i < 4; i++) notify(8'(20 + i), 0);
        quiet();
        chk(nlog == 4, "R10 four lines tracked", nlog, 4);
        c0 = int'(set_count);
        notify(8'd24, 0);
        quiet();
        chk(nlog == 4 && int'(set_count) == c0, "R10 fifth line ignored", nlog, 4);
        nlog = 0;
        writeback(8'd24, 8'h01, 64'h55);
        chk(nlog == 2 && is_set(0, 8'd24, 8'h01) && is_rst(1, 8'd24, 8'h01, 64'h55), "R10 full write", nlog, 2);
        for (int i = 0; i < 4; i++) writeback(8'(20 + i), 8'h01, 64'(i));

        // R9: entries freed, mask cleared
        nlog = 0;
        notify(8'd20, 0);
        quiet();
        chk(nlog == 1 && is_set(0, 8'd20, 8'h01), "R9 record cleared", nlog, 1);
        for (int i = 0; i < 3; i++) notify(8'(50 + i), 5);
        quiet();
        chk(nlog == 4, "R9 capacity restored", nlog, 4);
        writeback(8'd20, 8'h01, 64'h0);
        for (int i = 0; i < 3; i++) writeback(8'(50 + i), 8'h20, 64'h0);

        // R4: order across lines
        nlog = 0;
        notify(8'd40, 3);
        notify(8'd41, 1);
        notify(8'd42, 6);
        quiet();
        chk(nlog == 3 && is_set(0, 8'd40, 8'h08) && is_set(1, 8'd41, 8'h02) && is_set(2, 8'd42, 8'h40),
            "R4 oldest first", nlog, 3);
        writeback(8'd40, 8'h08, 64'h0);
        writeback(8'd41, 8'h02, 64'h0);
        writeback(8'd42, 8'h40, 64'h0);

        // R7: writeback during an in-flight early SET, one SET still queued
        nlog = 0;
        c0 = int'(set_count);
        notify(8'd60, 0);
        notify(8'd60, 1);
        writeback(8'd60, 8'h03, 64'hCAFE);
        quiet();
        chk(nlog == 3 && is_set(0, 8'd60, 8'h01) && is_set(1, 8'd60, 8'h02) &&
            is_rst(2, 8'd60, 8'h03, 64'hCAFE), "R7 wait and cancel", nlog, 3);
        chk(int'(set_count) - c0 == 2, "R7 R11 count", int'(set_count) - c0, 2);

        // R8: writeback beats a queued early SET
        nlog = 0;
        @(negedge clk);
        dn_valid = 1'b1; dn_line = 8'd70; dn_word = 3'd4;
        wb_valid = 1'b1; wb_line = 8'd71; wb_mask = 8'h10; wb_data = 64'h77;
        @(negedge clk);
        dn_valid = 1'b0;
        wb_valid = 1'b0;
        while (wb_busy) @(negedge clk);
        quiet();
        chk(nlog == 3 && is_set(0, 8'd71, 8'h10) && is_rst(1, 8'd71, 8'h10, 64'h77) &&
            is_set(2, 8'd70, 8'h10), "R8 writeback priority", nlog, 3);
        nlog = 0;
        writeback(8'd70, 8'h10, 64'h9);
        chk(nlog == 1 && is_rst(0, 8'd70, 8'h10, 64'h9), "R8 R5 follow-up", nlog, 1);

        summary();
    end

endmodule